// File: doc/BRIEF.md
# Upset-Tolerant Handshake Sequencer

This block is a four-state request/busy/done sequencer whose state register is built to survive a single-event upset. Each legal state is stored as a 5-bit code, and any two legal codes differ in at least three bit positions. A single flipped bit therefore always lands on a code that sits next to exactly one legal state. The block steers that code back to its legal neighbour and pulses a correction indication for one cycle.

A code that is two or more flips away from every legal state cannot be trusted. The block sends the machine back to idle and raises a fault flag that stays set until reset. Every one of the 32 register values is decoded, so no value can trap the machine.

A test input is XORed into the value written to the state register on each clock. A testbench can use it to plant single-bit and multi-bit upsets. The active-low reset input is synchronised inside the block: it asserts asynchronously and releases on the clock.

Top module: `upset_fsm`

## Requirements
- R1: The legal state codes are IDLE=5'b00000, REQ=5'b00111, BUSY=5'b11001 and DONE=5'b11110, and any two of them differ in at least three bits.
- R2: In IDLE the machine moves to REQ on a clock edge where `start_i` is 1, and otherwise stays in IDLE.
- R3: REQ moves to BUSY on the next edge whatever the inputs. BUSY moves to DONE on an edge where `complete_i` is 1. DONE moves to IDLE on an edge where `ack_i` is 1.
- R4: `busy_o` and `done_o` are registered. After each edge they are 1 exactly when the state chosen at that edge is BUSY or DONE respectively, and they are never both 1.
- R5: When the register holds a code one bit away from a legal state, the next state is computed as if the register held that legal state.
- R6: `corr_o` is 1 for exactly the one cycle that follows each edge at which the register held a distance-one code.
- R7: When the register holds a code at distance two or more from every legal state, the next state is IDLE and `fault_o` becomes 1. `fault_o` then stays 1 until reset, and the machine keeps working normally.
- R8: On every edge the value loaded into the state register is the code of the chosen next state XOR `inj_mask_i`. A zero mask has no effect.
- R9: While `rst_n` is 0 the register holds IDLE and all outputs are 0, and this takes effect without waiting for a clock. After `rst_n` rises, inputs are ignored for the first two clock edges, and the machine runs from the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserts asynchronously and is synchronised internally |
| start_i | input | 1 | Start request, taken in IDLE |
| complete_i | input | 1 | Work complete, taken in BUSY |
| ack_i | input | 1 | Acknowledge, taken in DONE |
| inj_mask_i | input | 5 | Test-only mask XORed into the next state register value |
| busy_o | output | 1 | Machine is in BUSY |
| done_o | output | 1 | Machine is in DONE |
| corr_o | output | 1 | One-cycle pulse: a single-bit upset was corrected |
| fault_o | output | 1 | Sticky flag: an uncorrectable code was seen |

## Verification
The assertions assume that the state register can only leave the legal set through a non-zero `inj_mask_i`. For that reason a correction pulse is always traced back to a mask applied two edges earlier. They also assume that any clean write leaves a legal code.

The stimulus plants upsets only through the mask and keeps the mask at zero during reset and the synchroniser release window. It covers every single-bit flip in every state, several far codes, and a stretch of random handshakes with sparse random masks.

// File: rtl/upset_fsm_pkg.sv
package upset_fsm_pkg;
  localparam int SW     = 5;
  localparam int NUM_ST = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_BUSY = 2'd2,
    ST_DONE = 2'd3
  } st_e;

  // R1: codes pairwise at least three bits apart
  function automatic logic [SW-1:0] code_of(st_e s);
    case (s)
      ST_IDLE: code_of = 5'b00000;
      ST_REQ:  code_of = 5'b00111;
      ST_BUSY: code_of = 5'b11001;
      default: code_of = 5'b11110;
    endcase
  endfunction
endpackage

// File: rtl/ufsm_rst_sync.sv
module ufsm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_o
);
  logic [STAGES-1:0] sh_q;

  // R9: asynchronous assertion, release after STAGES clock edges
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sh_q <= '0;
    else          sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_o = ~sh_q[STAGES-1];
endmodule

// File: rtl/ufsm_decoder.sv
module ufsm_decoder
  import upset_fsm_pkg::*;
(
  input  logic [SW-1:0] code_i,
  output st_e           parent_o,
  output logic          corr_o,
  output logic          far_o
);
  logic [NUM_ST-1:0] near;
  logic [NUM_ST-1:0] exact;

  for (genvar g = 0; g < NUM_ST; g++) begin : g_dist
    localparam logic [SW-1:0] CODE = code_of(st_e'(g));
    assign near[g]  = ($countones(code_i ^ CODE) <= 1);
    assign exact[g] = (code_i == CODE);
  end

  // R5: the legal state within one flip is unique
  always_comb begin
    parent_o = ST_IDLE;
    for (int i = 0; i < NUM_ST; i++) begin
      if (near[i]) parent_o = st_e'(i);
    end
  end

  assign corr_o = (|near) & ~(|exact);
  assign far_o  = ~(|near);
endmodule

// File: rtl/ufsm_next.sv
module ufsm_next
  import upset_fsm_pkg::*;
(
  input  st_e  cur_i,
  input  logic far_i,
  input  logic start_i,
  input  logic complete_i,
  input  logic ack_i,
  output st_e  ns_o
);
  always_comb begin
    if (far_i) begin
      ns_o = ST_IDLE;                    // R7 safe fallback
    end else begin
      unique case (cur_i)
        ST_IDLE: ns_o = start_i    ? ST_REQ  : ST_IDLE;  // R2
        ST_REQ:  ns_o = ST_BUSY;                         // R3
        ST_BUSY: ns_o = complete_i ? ST_DONE : ST_BUSY;
        ST_DONE: ns_o = ack_i      ? ST_IDLE : ST_DONE;
        default: ns_o = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/upset_fsm.sv
module upset_fsm
  import upset_fsm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          complete_i,
  input  logic          ack_i,
  input  logic [SW-1:0] inj_mask_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          corr_o,
  output logic          fault_o
);
  logic          rst;
  logic [SW-1:0] state_q;
  st_e           parent;
  st_e           ns;
  logic          near_hit;
  logic          far_hit;

  ufsm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_o   (rst)
  );

  ufsm_decoder u_dec (
    .code_i   (state_q),
    .parent_o (parent),
    .corr_o   (near_hit),
    .far_o    (far_hit)
  );

  ufsm_next u_nxt (
    .cur_i      (parent),
    .far_i      (far_hit),
    .start_i    (start_i),
    .complete_i (complete_i),
    .ack_i      (ack_i),
    .ns_o       (ns)
  );

  // R8: test mask folded into the register write
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q <= code_of(ST_IDLE);
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      corr_o  <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      state_q <= code_of(ns) ^ inj_mask_i;
      busy_o  <= (ns == ST_BUSY);
      done_o  <= (ns == ST_DONE);
      corr_o  <= near_hit;
      fault_o <= fault_o | far_hit;
    end
  end
endmodule

// File: rtl/upset_fsm_chk.sv
module upset_fsm_chk
  import upset_fsm_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic [SW-1:0] state_q,
  input logic [SW-1:0] inj_mask_i,
  input logic          ack_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          corr_o,
  input logic          fault_o
);
  logic legal;
  assign legal = (state_q == code_of(ST_IDLE)) || (state_q == code_of(ST_REQ)) ||
                 (state_q == code_of(ST_BUSY)) || (state_q == code_of(ST_DONE));

  p_clean_write_legal_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(inj_mask_i) == '0) |-> legal);

  p_busy_done_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  p_req_to_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == code_of(ST_REQ)) |=> busy_o);

  p_done_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == code_of(ST_DONE) && ack_i && inj_mask_i == '0) |=> (!done_o && !busy_o));

  p_corr_needs_mask_r6: assert property (@(posedge clk) disable iff (rst)
    corr_o |-> ($past(inj_mask_i, 2) != '0));

  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    fault_o |=> fault_o);

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |-> (!busy_o && !done_o && !corr_o && !fault_o));
endmodule

bind upset_fsm upset_fsm_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .state_q    (state_q),
  .inj_mask_i (inj_mask_i),
  .ack_i      (ack_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .corr_o     (corr_o),
  .fault_o    (fault_o)
);

// File: tb/upset_fsm_tb.sv
module upset_fsm_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       start_i = 1'b0, complete_i = 1'b0, ack_i = 1'b0;
  logic [4:0] inj_mask_i = 5'd0;
  logic       busy_o, done_o, corr_o, fault_o;

  int checks = 0;
  int errors = 0;
  logic cmp_en = 1'b1;

  always #10 clk = ~clk;  // 50 MHz

  upset_fsm u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .complete_i(complete_i),
    .ack_i(ack_i), .inj_mask_i(inj_mask_i), .busy_o(busy_o), .done_o(done_o),
    .corr_o(corr_o), .fault_o(fault_o)
  );

  // Reference model (R1 codes: 0=IDLE 1=REQ 2=BUSY 3=DONE)
  logic [4:0] codes [4] = '{5'b00000, 5'b00111, 5'b11001, 5'b11110};
  logic [4:0] m_reg = 5'd0;
  logic m_busy = 0, m_done = 0, m_corr = 0, m_fault = 0;
  int par, dmin, nxt;

  function automatic int hd(logic [4:0] a, logic [4:0] b);
    int n = 0;
    for (int i = 0; i < 5; i++) n += int'(a[i] ^ b[i]);
    return n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 5'd0; m_busy = 0; m_done = 0; m_corr = 0; m_fault = 0;
    end else begin
      par = -1; dmin = 9;
      for (int k = 0; k < 4; k++)
        if (hd(m_reg, codes[k]) <= 1) begin par = k; dmin = hd(m_reg, codes[k]); end
      if (par < 0) begin
        nxt = 0; m_fault = 1; m_corr = 0;
      end else begin
        m_corr = (dmin == 1);
        case (par)
          0:       nxt = start_i ? 1 : 0;
          1:       nxt = 2;
          2:       nxt = complete_i ? 3 : 2;
          default: nxt = ack_i ? 0 : 3;
        endcase
      end
      m_reg  = codes[nxt] ^ inj_mask_i;
      m_busy = (nxt == 2);
      m_done = (nxt == 3);
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic tick(logic s, logic c, logic a, logic [4:0] m);
    start_i = s; complete_i = c; ack_i = a; inj_mask_i = m;
    @(posedge clk);
    @(negedge clk);
    start_i = 0; complete_i = 0; ack_i = 0; inj_mask_i = 5'd0;
    if (cmp_en && rst_n) begin
      chk("R4", "busy_o", busy_o, m_busy);
      chk("R4", "done_o", done_o, m_done);
      chk("R6", "corr_o", corr_o, m_corr);
      chk("R7", "fault_o", fault_o, m_fault);
    end
  endtask

  task automatic go_idle();
    repeat (4) tick(0, 1, 1, 5'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    #2;
    // R9: asynchronous clearing
    chk("R9", "busy_o in reset", busy_o, 1'b0);
    chk("R9", "fault_o in reset", fault_o, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) tick(0, 0, 0, 5'd0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R9", "busy_o after reset", busy_o, 1'b0);
    chk("R9", "corr_o after reset", corr_o, 1'b0);
    rst_n = 1;
    repeat (3) tick(0, 0, 0, 5'd0);

    // R2, R3: full handshake with waits
    tick(0, 0, 0, 5'd0);
    tick(1, 0, 0, 5'd0);
    chk("R2", "busy_o in REQ", busy_o, 1'b0);
    tick(0, 0, 0, 5'd0);
    chk("R3", "busy_o after REQ", busy_o, 1'b1);
    tick(0, 0, 1, 5'd0);
    chk("R3", "busy_o holds", busy_o, 1'b1);
    tick(0, 1, 0, 5'd0);
    chk("R3", "done_o", done_o, 1'b1);
    tick(1, 0, 0, 5'd0);
    chk("R3", "done_o holds", done_o, 1'b1);
    tick(0, 0, 1, 5'd0);
    chk("R3", "done_o cleared", done_o, 1'b0);

    // R1, R5, R6, R8: every single-bit flip in every state
    for (int b = 0; b < 5; b++) begin
      tick(0, 0, 0, 5'(1 << b));
      tick(0, 0, 0, 5'd0);
      chk("R6", "corr_o pulse IDLE", corr_o, 1'b1);
      tick(0, 0, 0, 5'd0);
      chk("R6", "corr_o one cycle", corr_o, 1'b0);
      chk("R1", "no fault on single flip", fault_o, 1'b0);

      tick(1, 0, 0, 5'(1 << b));
      tick(0, 0, 0, 5'd0);
      chk("R5", "REQ corrected to BUSY", busy_o, 1'b1);
      go_idle();

      tick(1, 0, 0, 5'd0);
      tick(0, 0, 0, 5'(1 << b));
      tick(0, 1, 0, 5'd0);
      chk("R5", "BUSY corrected to DONE", done_o, 1'b1);
      go_idle();

      tick(1, 0, 0, 5'd0);
      tick(0, 0, 0, 5'd0);
      tick(0, 1, 0, 5'(1 << b));
      tick(0, 0, 0, 5'd0);
      chk("R5", "DONE held", done_o, 1'b1);
      tick(0, 0, 1, 5'd0);
      chk("R5", "DONE acked", done_o, 1'b0);
    end

    // R7: far code from IDLE (00000^01010)
    tick(0, 0, 0, 5'b01010);
    tick(1, 0, 0, 5'd0);
    chk("R7", "fault_o set", fault_o, 1'b1);
    chk("R7", "recovered to IDLE", busy_o, 1'b0);
    tick(1, 0, 0, 5'd0);
    tick(0, 0, 0, 5'd0);
    chk("R7", "operation resumes", busy_o, 1'b1);
    chk("R7", "fault_o sticky", fault_o, 1'b1);
    // far code from BUSY (11001^10011 = 01010)
    tick(0, 0, 0, 5'b10011);
    tick(0, 1, 0, 5'd0);
    chk("R7", "far from BUSY goes IDLE", done_o, 1'b0);
    repeat (5) tick(0, 0, 0, 5'd0);
    chk("R7", "fault_o still set", fault_o, 1'b1);

    do_reset();
    chk("R9", "fault_o cleared by reset", fault_o, 1'b0);

    // Random handshakes with sparse masks
    for (int n = 0; n < 600; n++) begin
      tick(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
           ($urandom % 8 == 0) ? 5'($urandom % 32) : 5'd0);
    end

    // R9: synchronous release, two edges ignored
    do_reset();
    cmp_en = 0;
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    start_i = 1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    start_i = 0;
    chk("R9", "busy_o before release done", busy_o, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R9", "busy_o after release", busy_o, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule